// File: doc/BRIEF.md
# ID Resistor Classification Sequencer

This block decides which of four resistance classes sits on a cable's ID pin during charger-adapter detection. It has no analog parts. It drives an external comparator that watches the ID voltage against one of several selectable thresholds, and it reads that comparator's single-bit answer. Two decisions, one after the other, form a binary search.

A start pulse in idle moves the FSM from `IDLE` to `PROBE_MID`. In that step the comparator path is enabled, the ID source select is driven to 0 and the threshold select is set to 2, all in the same cycle.

The settle timer then counts at least `ceil(CLK_FREQ_HZ * SETTLE_US / 1e6)` cycles before the comparator is sampled:
- A sample of 1 takes the transition `PROBE_MID -> PROBE_HIGH`, with threshold 3.
- A sample of 0 takes the transition `PROBE_MID -> PROBE_LOW`, with threshold 1.

After a second full settle wait, the FSM samples again, takes the transition back to `IDLE`, registers the class and raises `done_o` for one cycle. The comparator enable is released in that same cycle.

Top module: `rid_classifier`

## Requirements
- R1: After reset, `cmp_en_o`=0, `thr_sel_o`=0, `done_o`=0 and `rid_class_o`=0.
- R2: The cycle after a start pulse is sampled in idle, `cmp_en_o`=1, `id_src_o`=0 and `thr_sel_o`=2.
- R3: Each threshold value is held for at least `ceil(CLK_FREQ_HZ*SETTLE_US/1e6)` clock cycles before the comparator is sampled under it. The wait is never shorter.
- R4: If the first sample is 1, the threshold moves to 3. If it is 0, the threshold moves to 1.
- R5: On the threshold-3 branch, a second sample of 1 gives class FLOAT (code 0) and a 0 gives class A (code 1).
- R6: On the threshold-1 branch, a second sample of 1 gives class B (code 2) and a 0 gives class C (code 3).
- R7: Throughout a sequence, `cmp_en_o` stays 1 and `id_src_o` stays 0. In idle, `cmp_en_o` is 0.
- R8: `done_o` is high for exactly one cycle. In that cycle `rid_class_o` carries the result, and it keeps that value until the next completion.
- R9: A start pulse during a sequence is ignored. The threshold schedule and completion time are unchanged.
- R10: Asserting reset mid-sequence returns the block to idle with `cmp_en_o`=0 and no `done_o` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, acted on only in idle |
| cmp_i | input | 1 | Filtered ID comparator result |
| cmp_en_o | output | 1 | ID comparator path enable |
| id_src_o | output | 1 | ID source select, 0 during a sequence |
| thr_sel_o | output | 2 | Comparator threshold select |
| rid_class_o | output | 2 | Class: 0 FLOAT, 1 A, 2 B, 3 C |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The situation that is hardest to reach from the ports is the exact cycle at which the settle timer lets a sample through. An off-by-one there only shows up as a threshold change one cycle early or late. The bench therefore counts negedges from the start edge and checks the threshold one cycle before and one cycle after each expected switch.

The bench clock frequency is chosen so that the cycle count needs rounding up. The comparator is modelled as an ID voltage level compared against the selected threshold, so all four classes come out of the real branch path. A start pulse is injected in the middle of a wait, and a reset is applied in the middle of a wait.

// File: rtl/rid_pkg.sv
package rid_pkg;
    typedef enum logic [1:0] {
        RID_FLOAT = 2'd0,
        RID_A     = 2'd1,
        RID_B     = 2'd2,
        RID_C     = 2'd3
    } rid_class_t;

    typedef enum logic [1:0] {
        IDLE       = 2'd0,
        PROBE_MID  = 2'd1,
        PROBE_HIGH = 2'd2,
        PROBE_LOW  = 2'd3
    } rid_state_t;

    localparam logic [1:0] THR_NONE = 2'd0;
    localparam logic [1:0] THR_LOW  = 2'd1;
    localparam logic [1:0] THR_MID  = 2'd2;
    localparam logic [1:0] THR_HIGH = 2'd3;
endpackage

// File: rtl/rid_settle_timer.sv
module rid_settle_timer #(
    parameter longint unsigned CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    output logic expired_o
);
    localparam int CNT_W = (CYCLES > 2) ? $clog2(CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt_q <= '0;
        else if (clear_i)    cnt_q <= '0;
        else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
    end

    assign expired_o = (cnt_q == LAST);

    // the count never runs past the last value (R3)
    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
    // expiry is only reached by counting up, never by jumping (R3)
    assert_expiry_by_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(expired_o) && CYCLES > 1 |-> $past(cnt_q) == LAST - 1'b1);
endmodule

// File: rtl/rid_fsm.sv
module rid_fsm
    import rid_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       cmp_i,
    input  logic       expired_i,
    output logic       timer_clr_o,
    output logic       cmp_en_o,
    output logic       id_src_o,
    output logic [1:0] thr_sel_o,
    output logic [1:0] rid_class_o,
    output logic       done_o
);
    rid_state_t state_q, state_d;
    rid_class_t class_q, class_d;
    logic       done_q, done_d;

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IDLE;
            class_q <= RID_FLOAT;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            class_q <= class_d;
            done_q  <= done_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        class_d = class_q;
        done_d  = 1'b0;
        unique case (state_q)
            IDLE: begin
                if (start_i) state_d = PROBE_MID;
            end
            PROBE_MID: begin
                if (expired_i) state_d = cmp_i ? PROBE_HIGH : PROBE_LOW;
            end
            PROBE_HIGH: begin
                if (expired_i) begin
                    state_d = IDLE;
                    class_d = cmp_i ? RID_FLOAT : RID_A;
                    done_d  = 1'b1;
                end
            end
            PROBE_LOW: begin
                if (expired_i) begin
                    state_d = IDLE;
                    class_d = cmp_i ? RID_B : RID_C;
                    done_d  = 1'b1;
                end
            end
        endcase
    end

    // output process
    always_comb begin
        cmp_en_o    = 1'b0;
        id_src_o    = 1'b0;
        thr_sel_o   = THR_NONE;
        timer_clr_o = expired_i;
        unique case (state_q)
            IDLE: begin
                timer_clr_o = 1'b1;
            end
            PROBE_MID: begin
                cmp_en_o  = 1'b1;
                thr_sel_o = THR_MID;
            end
            PROBE_HIGH: begin
                cmp_en_o  = 1'b1;
                thr_sel_o = THR_HIGH;
            end
            PROBE_LOW: begin
                cmp_en_o  = 1'b1;
                thr_sel_o = THR_LOW;
            end
        endcase
    end

    assign rid_class_o = class_q;
    assign done_o      = done_q;

    // a threshold change during a sequence follows a timer expiry (R3)
    assert_thr_after_settle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_en_o && $past(cmp_en_o) && thr_sel_o != $past(thr_sel_o)) |-> $past(expired_i));
    // the first branch goes to 3 or 1 only from 2 (R4)
    assert_branch_from_mid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_en_o && $past(cmp_en_o) && thr_sel_o != $past(thr_sel_o))
            |-> $past(thr_sel_o) == THR_MID && thr_sel_o != THR_NONE);
    // source stays 0 while the comparator is enabled (R7)
    assert_src_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_en_o |-> !id_src_o);
    // enable drops only together with a done pulse (R7)
    assert_en_until_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cmp_en_o) |-> done_o);
    // done lasts one cycle and the class holds afterwards (R8)
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o && $stable(rid_class_o));
    // a new sequence starts at the middle threshold (R2)
    assert_start_mid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmp_en_o) |-> thr_sel_o == THR_MID);
endmodule

// File: rtl/rid_classifier.sv
module rid_classifier #(
    parameter longint unsigned CLK_FREQ_HZ = 48_000_000,
    parameter longint unsigned SETTLE_US   = 560
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       cmp_i,
    output logic       cmp_en_o,
    output logic       id_src_o,
    output logic [1:0] thr_sel_o,
    output logic [1:0] rid_class_o,
    output logic       done_o
);
    localparam longint unsigned RAW_CYC = (CLK_FREQ_HZ * SETTLE_US + 64'd999_999) / 64'd1_000_000;
    localparam longint unsigned SETTLE_CYC = (RAW_CYC < 2) ? 2 : RAW_CYC;

    logic timer_clr;
    logic expired;

    rid_settle_timer #(.CYCLES(SETTLE_CYC)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (timer_clr),
        .expired_o (expired)
    );

    rid_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .cmp_i       (cmp_i),
        .expired_i   (expired),
        .timer_clr_o (timer_clr),
        .cmp_en_o    (cmp_en_o),
        .id_src_o    (id_src_o),
        .thr_sel_o   (thr_sel_o),
        .rid_class_o (rid_class_o),
        .done_o      (done_o)
    );
endmodule

// File: tb/rid_classifier_test.sv
module rid_classifier_test;
    localparam time CLK_PERIOD = 10ns;
    localparam longint unsigned F_HZ = 110_000;
    // 110000 Hz * 560 us = 61.6 cycles, rounded up
    localparam int N = 62;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       cmp_i;
    logic       cmp_en_o, id_src_o, done_o;
    logic [1:0] thr_sel_o, rid_class_o;
    int         vlevel = 0;
    int         checks = 0;
    int         errors = 0;
    bit         finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // comparator model: ID voltage level above selected threshold
    assign cmp_i = cmp_en_o && (vlevel > int'(thr_sel_o));

    rid_classifier #(.CLK_FREQ_HZ(F_HZ), .SETTLE_US(560)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmp_i(cmp_i),
        .cmp_en_o(cmp_en_o), .id_src_o(id_src_o), .thr_sel_o(thr_sel_o),
        .rid_class_o(rid_class_o), .done_o(done_o)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", "cmp_en", int'(cmp_en_o), 0);
        check("R1", "thr", int'(thr_sel_o), 0);
        check("R1", "done", int'(done_o), 0);
        check("R1", "class", int'(rid_class_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // level: 4 FLOAT, 3 A, 2 B, 1 C
    task automatic run_class(input int level, input int exp_thr2, input int exp_cls, input bit poke);
        vlevel = level;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check("R2", "thr after start", int'(thr_sel_o), 2);
        check("R7", "en after start", int'(cmp_en_o), 1);
        check("R7", "src after start", int'(id_src_o), 0);
        if (poke) begin
            repeat (10) @(negedge clk);
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            repeat (N - 1 - 11) @(negedge clk);
        end else begin
            repeat (N - 1) @(negedge clk);
        end
        check(poke ? "R9" : "R3", "thr before first switch", int'(thr_sel_o), 2);
        @(negedge clk);
        check("R4", "thr after first sample", int'(thr_sel_o), exp_thr2);
        repeat (N - 1) @(negedge clk);
        check("R3", "thr before second sample", int'(thr_sel_o), exp_thr2);
        check("R8", "no early done", int'(done_o), 0);
        check("R7", "en held", int'(cmp_en_o), 1);
        @(negedge clk);
        check("R8", "done pulse", int'(done_o), 1);
        check(exp_thr2 == 3 ? "R5" : "R6", "class", int'(rid_class_o), exp_cls);
        check("R7", "en released", int'(cmp_en_o), 0);
        @(negedge clk);
        check("R8", "done single", int'(done_o), 0);
        check("R8", "class held", int'(rid_class_o), exp_cls);
        check(poke ? "R9" : "R7", "stays idle", int'(cmp_en_o), 0);
        repeat (3) @(negedge clk);
    endtask

    task automatic test_mid_reset();
        bit seen_done = 1'b0;
        vlevel = 2;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (20) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R10", "en in reset", int'(cmp_en_o), 0);
        check("R10", "thr in reset", int'(thr_sel_o), 0);
        rst_n = 1'b1;
        for (int i = 0; i < 3 * N; i++) begin
            @(negedge clk);
            if (done_o || cmp_en_o) seen_done = 1'b1;
        end
        check("R10", "no activity after reset", int'(seen_done), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        test_reset();
        run_class(4, 3, 0, 1'b0);
        run_class(3, 3, 1, 1'b0);
        run_class(2, 1, 2, 1'b0);
        run_class(1, 1, 3, 1'b0);
        run_class(0, 1, 3, 1'b1);
        test_mid_reset();
        run_class(3, 3, 1, 1'b0);
        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule